// File: doc/BRIEF.md
# Register-Driven Serial Flash Command Engine

This block lets a processor run one serial-flash transaction at a time through three 32-bit registers. Software writes a command word that holds the flash command byte and a 24-bit flash address. It puts any program payload in the data word. It then writes the control word with a transmit byte count, a receive byte count and the launch bit set. The engine drives chip select low and clocks out the command and address bytes, followed by payload bytes when the transmit count asks for them. It then clocks in up to four reply bytes, stores them little-endian in the data word, and drops its busy flag.

The serial side uses mode 0 with every byte most-significant bit first. The serial clock is the system clock divided by an even ratio set by a parameter. Software polls busy before it loads a new command and again after it launches one. Every register write made while busy is set is discarded. Splitting writes at page boundaries, polling flash status and probing the flash size are left to software.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset every register reads zero, chip select is high and the serial clock is low. The register map is: address 0 is the command word (command byte in bits 7:0, flash address in bits 31:8); address 1 is control (transmit count in bits 3:0, receive count in bits 7:4, launch in bit 8, busy in bit 16); address 2 is the data word; address 3 reads zero. Control reads back the written counts. The launch bit always reads 0, and busy is read-only.
- R2: The first transmitted byte is the command byte, followed by address bits 23:16, 15:8 and 7:0, limited to as many bytes as the transmit count allows.
- R3: Transmit bytes 5 to 8 come from the data word, bits 7:0 first, then 15:8, 23:16 and 31:24. A transmit count above 8 behaves as 8.
- R4: The receive bytes follow the transmit bytes while MOSI is held low. The first received byte lands in data bits 7:0, the next in 15:8, and so on. Data bytes above the received count read zero. A receive count above 4 behaves as 4. A receive count of 0 leaves the data word unchanged.
- R5: The serial clock idles low and toggles only while chip select is low. Each byte takes exactly 8 clock pulses, MSB first. MOSI changes after a falling edge and MISO is sampled on the rising edge. The clock period is DIV system clocks.
- R6: Chip select goes low exactly once per launched transfer and stays low across all transmit and receive bytes.
- R7: Busy reads 1 in the first cycle after an accepted launch and stays 1 until chip select has returned high. The data word takes its received value in the same cycle that busy falls.
- R8: Writes to the command, data and control words while busy is set have no effect, and that includes a launch request.
- R9: A launch with a transmit count of 0 completes at once. Chip select is never asserted, busy stays 0 and the data word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 command, 1 control, 2 data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
If the byte index or the transmit/receive split is wrong, the very next transfer shows it. A transmitted byte comes out wrong or misplaced on MOSI, or a reply byte lands in the wrong lane of the data word, and both can be seen within one byte time of the slip. A bit counter that is off by one changes the number of clock pulses inside the chip-select window, which the bench compares with eight per byte. A busy flag that falls early either drops chip select before the last byte or lets a discarded write through, and a read of the command word after the transfer exposes the second case.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] TX_LIMIT = 4'd8;
  localparam logic [CNT_W-1:0] RX_LIMIT = 4'd4;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_FIN   = 2'd2
  } seq_state_t;

  function automatic logic [CNT_W-1:0] clamp_tx(input logic [CNT_W-1:0] n);
    return (n > TX_LIMIT) ? TX_LIMIT : n;
  endfunction

  function automatic logic [CNT_W-1:0] clamp_rx(input logic [CNT_W-1:0] n);
    return (n > RX_LIMIT) ? RX_LIMIT : n;
  endfunction

  // Byte k of the outgoing stream: command, address high to low, then payload LSB first.
  function automatic logic [7:0] tx_byte(input logic [31:0] cmd,
                                         input logic [31:0] pay,
                                         input logic [CNT_W-1:0] k);
    case (k)
      4'd0:    return cmd[7:0];
      4'd1:    return cmd[31:24];
      4'd2:    return cmd[23:16];
      4'd3:    return cmd[15:8];
      4'd4:    return pay[7:0];
      4'd5:    return pay[15:8];
      4'd6:    return pay[23:16];
      4'd7:    return pay[31:24];
      default: return 8'h00;
    endcase
  endfunction

  // Place received byte number k into its little-endian lane.
  function automatic logic [31:0] put_rx(input logic [31:0] w,
                                         input logic [CNT_W-1:0] k,
                                         input logic [7:0] b);
    logic [31:0] r;
    r = w;
    case (k)
      4'd0:    r[7:0]   = b;
      4'd1:    r[15:8]  = b;
      4'd2:    r[23:16] = b;
      4'd3:    r[31:24] = b;
      default: r = w;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)   cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             busy,
  input  logic             rx_load,
  input  logic [31:0]      rx_word,
  output logic [31:0]      cmd_q,
  output logic [31:0]      data_q,
  output logic             go,
  output logic [CNT_W-1:0] go_tx,
  output logic [CNT_W-1:0] go_rx
);
  logic [CNT_W-1:0] tx_q, rx_q;
  logic             wr_ok;

  assign wr_ok = we && !busy;
  assign go    = wr_ok && (addr == 2'd1) && wdata[8];
  assign go_tx = wdata[3:0];
  assign go_rx = wdata[7:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      if (wr_ok && addr == 2'd0) cmd_q <= wdata;
      if (wr_ok && addr == 2'd1) begin
        tx_q <= wdata[3:0];
        rx_q <= wdata[7:4];
      end
      if (rx_load)                    data_q <= rx_word;
      else if (wr_ok && addr == 2'd2) data_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = cmd_q;
      2'd1:    rdata = {15'b0, busy, 7'b0, 1'b0, rx_q, tx_q};
      2'd2:    rdata = data_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] go_tx,
  input  logic [CNT_W-1:0] go_rx,
  input  logic [31:0]      cmd,
  input  logic [31:0]      pay,
  input  logic             miso,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  output logic             busy,
  output logic             rx_phase,
  output logic             rx_load,
  output logic [31:0]      rx_word
);
  seq_state_t       st;
  logic [7:0]       sh;
  logic [2:0]       bit_i;
  logic [CNT_W-1:0] byte_i, n_tx, n_tot, t_eff, nxt_i;
  logic             rx_bit, tick;
  logic [7:0]       got;

  spi_cmd_clkdiv #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st == SQ_SHIFT),
    .tick (tick)
  );

  assign t_eff    = clamp_tx(go_tx);
  assign nxt_i    = byte_i + 4'd1;
  assign got      = {sh[6:0], rx_bit};
  assign busy     = (st != SQ_IDLE);
  assign rx_phase = (st == SQ_SHIFT) && (byte_i >= n_tx);
  assign mosi     = rx_phase ? 1'b0 : sh[7];
  assign rx_load  = (st == SQ_FIN) && (n_tot != n_tx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
      sh      <= '0;
      bit_i   <= '0;
      byte_i  <= '0;
      n_tx    <= '0;
      n_tot   <= '0;
      rx_bit  <= 1'b0;
      rx_word <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (go && t_eff != '0) begin
            st      <= SQ_SHIFT;
            cs_n    <= 1'b0;
            sck     <= 1'b0;
            n_tx    <= t_eff;
            n_tot   <= t_eff + clamp_rx(go_rx);
            byte_i  <= '0;
            bit_i   <= '0;
            sh      <= tx_byte(cmd, pay, 4'd0);
            rx_word <= '0;
          end
        end
        SQ_SHIFT: begin
          if (tick) begin
            if (!sck) begin
              sck    <= 1'b1;
              rx_bit <= miso;
            end else begin
              sck <= 1'b0;
              if (bit_i == 3'd7) begin
                bit_i <= '0;
                if (byte_i >= n_tx) rx_word <= put_rx(rx_word, byte_i - n_tx, got);
                if (byte_i == n_tot - 4'd1) begin
                  st   <= SQ_FIN;
                  cs_n <= 1'b1;
                end else begin
                  byte_i <= nxt_i;
                  sh     <= (nxt_i < n_tx) ? tx_byte(cmd, pay, nxt_i) : 8'h00;
                end
              end else begin
                bit_i <= bit_i + 3'd1;
                sh    <= got;
              end
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic             busy_w, go_w, rx_load_w, rx_phase_w;
  logic [CNT_W-1:0] go_tx_w, go_rx_w;
  logic [31:0]      cmd_w, data_w, rx_word_w;

  spi_cmd_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .busy   (busy_w),
    .rx_load(rx_load_w),
    .rx_word(rx_word_w),
    .cmd_q  (cmd_w),
    .data_q (data_w),
    .go     (go_w),
    .go_tx  (go_tx_w),
    .go_rx  (go_rx_w)
  );

  spi_cmd_seq #(.DIV(DIV)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go_w),
    .go_tx   (go_tx_w),
    .go_rx   (go_rx_w),
    .cmd     (cmd_w),
    .pay     (data_w),
    .miso    (spi_miso),
    .sck     (spi_sck),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .busy    (busy_w),
    .rx_phase(rx_phase_w),
    .rx_load (rx_load_w),
    .rx_word (rx_word_w)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic        spi_sck,
  input logic        spi_cs_n,
  input logic        spi_mosi,
  input logic        busy,
  input logic        go,
  input logic [3:0]  go_tx,
  input logic        rx_phase,
  input logic [31:0] cmd
);
  // R6
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);

  // R7
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> busy);

  // R7
  busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && go_tx != 4'd0) |=> (busy && !spi_cs_n));

  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R5
  sck_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_sck) |-> !$past(spi_cs_n));

  // R4
  mosi_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_phase |-> !spi_mosi);

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == 2'd0) |=> $stable(cmd));

  // R9
  zero_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && go_tx == 4'd0) |=> (!busy && spi_cs_n));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_we  (reg_we),
  .reg_addr(reg_addr),
  .spi_sck (spi_sck),
  .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi),
  .busy    (busy_w),
  .go      (go_w),
  .go_tx   (go_tx_w),
  .rx_phase(rx_phase_w),
  .cmd     (cmd_w)
);

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int errs = 0;
  int checks = 0;

  spi_cmd_engine #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #10 clk = ~clk;

  // Flash-side model: logs MOSI on rising SCK, drives MISO from a reply pattern.
  logic [63:0] reply = '0;
  logic [7:0]  mlog [0:15];
  logic        prev_sck = 1'b0, prev_cs = 1'b1;
  int nbits = 0, cs_falls = 0, mpos = 0, clkcnt = 0, last_rise = 0, period = 0;

  always @(negedge clk) begin
    clkcnt++;
    if (prev_cs && !spi_cs_n) begin
      nbits = 0; cs_falls++; mpos = 0; spi_miso = reply[63];
    end
    if (!prev_sck && spi_sck) begin
      if (nbits < 128) mlog[nbits/8] = {mlog[nbits/8][6:0], spi_mosi};
      nbits++;
      period = clkcnt - last_rise;
      last_rise = clkcnt;
    end
    if (prev_sck && !spi_sck && !spi_cs_n) begin
      mpos++;
      spi_miso = (mpos < 64) ? reply[63-mpos] : 1'b0;
    end
    prev_sck = spi_sck;
    prev_cs = spi_cs_n;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [7:0] exp_mosi(input logic [31:0] op, input logic [31:0] dat, input int k, input int txe);
    if (k >= txe) return 8'h00;
    if (k == 0) return op[7:0];
    if (k < 4) return 8'((op >> (8*(4-k))) & 32'hFF);
    return 8'((dat >> (8*(k-4))) & 32'hFF);
  endfunction

  task automatic wait_idle();
    int n = 0;
    logic [31:0] c;
    rd(2'd1, c);
    while (c[16] && n < 5000) begin
      @(negedge clk);
      n++;
      rd(2'd1, c);
    end
  endtask

  task automatic run(input logic [31:0] op, input logic [31:0] dat, input int tx, input int rx, input logic [63:0] pat);
    int txe, rxe, f0;
    logic [31:0] v, expd;
    txe = (tx > 8) ? 8 : tx;
    rxe = (rx > 4) ? 4 : rx;
    reply = pat;
    f0 = cs_falls;
    wr(2'd0, op);
    wr(2'd2, dat);
    wr(2'd1, {23'b0, 1'b1, 4'(rx), 4'(tx)});
    rd(2'd1, v);
    // R7 busy visible in the first cycle after launch (R9: never for tx 0)
    if (txe != 0) chk(v[16] == 1'b1, "R7 busy after launch", 64'(v[16]), 64'd1);
    else          chk(v[16] == 1'b0, "R9 busy stays low", 64'(v[16]), 64'd0);
    wait_idle();
    // R1 control readback: counts as written, launch bit reads 0
    rd(2'd1, v);
    chk(v == {24'b0, 4'(rx), 4'(tx)}, "R1 control readback", 64'(v), 64'({24'b0, 4'(rx), 4'(tx)}));
    expd = dat;
    if (txe != 0 && rxe != 0) begin
      expd = '0;
      for (int k = 0; k < rxe; k++)
        expd = expd | (32'((pat >> (56 - 8*(txe+k))) & 64'hFF) << (8*k));
    end
    rd(2'd2, v);
    if (txe == 0) begin
      chk(cs_falls == f0, "R9 no chip select", 64'(cs_falls - f0), 64'd0);
      chk(v == dat, "R9 data unchanged", 64'(v), 64'(dat));
    end else begin
      chk(v == expd, "R4 received data word", 64'(v), 64'(expd));
      chk(cs_falls == f0 + 1, "R6 single chip-select window", 64'(cs_falls - f0), 64'd1);
      chk(nbits == 8*(txe+rxe), "R5 clock pulses", 64'(nbits), 64'(8*(txe+rxe)));
      chk(period == DIV, "R5 clock period", 64'(period), 64'(DIV));
      for (int k = 0; k < txe + rxe; k++) begin
        logic [7:0] e;
        e = exp_mosi(op, dat, k, txe);
        chk(mlog[k] == e, (k < 4) ? "R2 command/address byte" : (k < txe ? "R3 payload byte" : "R4 MOSI low in receive"),
            64'(mlog[k]), 64'(e));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL all: watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1 reset command word", 64'(v), 64'd0);
    rd(2'd1, v); chk(v == 0, "R1 reset control", 64'(v), 64'd0);
    rd(2'd2, v); chk(v == 0, "R1 reset data word", 64'(v), 64'd0);
    rd(2'd3, v); chk(v == 0, "R1 address 3 reads zero", 64'(v), 64'd0);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 idle pins", {62'b0, spi_cs_n, spi_sck}, 64'd2);

    // R2 R3 R4 R5 R6 R7 R9 sweep over all legal count pairs
    for (int tx = 0; tx <= 8; tx++)
      for (int rx = 0; rx <= 4; rx++)
        run(32'h5A3C_9600 ^ (32'(tx) * 32'h0101_0101) ^ 32'(rx),
            32'hC1D2_E3F4 ^ (32'(rx) * 32'h1100_0011),
            tx, rx,
            64'hC3A5_0F1E_7788_99F0 ^ (64'(tx*5+rx) * 64'h0102_0408_1020_4080));

    // R3 R4 counts above the limits behave as 8 and 4
    run(32'hABCD_EF02, 32'h1122_3344, 15, 15, 64'h8877_6655_4433_2211);
    run(32'h0010_2003, 32'h99AA_BBCC, 10, 6, 64'hF0E1_D2C3_B4A5_9687);

    // R8 writes during busy are discarded
    run(32'h0000_0006, 32'h0BAD_F00D, 0, 0, 64'h0);
    f0 = cs_falls;
    wr(2'd0, 32'h0000_0006);
    wr(2'd1, 32'h0000_0101);
    wr(2'd0, 32'hDEAD_BEEF);
    wr(2'd2, 32'h1234_5678);
    wr(2'd1, 32'h0000_0144);
    wait_idle();
    repeat (100) @(negedge clk);
    rd(2'd0, v); chk(v == 32'h0000_0006, "R8 command write ignored", 64'(v), 64'h6);
    rd(2'd2, v); chk(v == 32'h0BAD_F00D, "R8 data write ignored", 64'(v), 64'h0BAD_F00D);
    rd(2'd1, v); chk(v == 32'h0000_0001, "R8 control write ignored", 64'(v), 64'h1);
    chk(cs_falls == f0 + 1, "R8 launch while busy ignored", 64'(cs_falls - f0), 64'd1);
    chk(mlog[0] == 8'h06, "R2 single command byte", 64'(mlog[0]), 64'h06);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule